// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block is the register side of a 54-pin general-purpose I/O port, reached through a plain 32-bit word-addressed read/write bus. Every pin has a 3-bit function code, and the codes are packed ten to a word. Code 0 makes the pin an input, code 1 makes it a driven output, and codes 2 to 7 hand the pin to one of six alternate functions. The block exports each pin's function code so that a pad multiplexer outside the block can act on it.

Output levels are never written directly. Software writes ones into a set word to drive pins high and ones into a clear word to drive them low. Writing zeros to either word has no effect. Live pin levels pass through a two-flop synchroniser and are read back from two level words.

Pull resistors are programmed in two steps. A single shared control word holds the pull mode. A pin copies that mode only when software writes a 1 to that pin's bit in a pull-strobe word. The expected sequence is: write the mode, strobe the pins, then write zero to both registers. The pads and the analog pull circuits are outside this block.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every pin has function code 0, output enable low, stored output 0 and pull state 0. The pull control word and every function word read 0.
- R2: The function code of pin n is held in bits [3*(n%10)+2 : 3*(n%10)] of the word at byte offset 4*(n/10), starting at 0x00. A read returns the code written for each existing pin. Bits that belong to no pin (bits 30 and 31, and bits 12 to 31 of word 0x14) read 0. `pin_func` carries pin n's code on bits [3n+2:3n].
- R3: A write to a set word (0x1C for pins 0 to 31, 0x20 for pins 32 to 53, bit n%32) drives the stored output of every pin whose bit is 1 high on the next clock. Pins whose bit is 0 keep their value.
- R4: A write to a clear word (0x28, 0x2C, same bit mapping as R3) drives the stored output of every pin whose bit is 1 low. A bit of 0 has no effect.
- R5: `pin_oe[n]` is high exactly when pin n's function code is 1. Set and clear writes update the stored output even while the pin is not an output.
- R6: The level words (0x34 for pins 0 to 31, 0x38 for pins 32 to 53) return `pin_in` through a two-flop synchroniser. A change at the input shows up two clock edges later. Bits that belong to no pin read 0.
- R7: The pull control word at 0x94 holds a 2-bit mode (0 none, 1 pull-down, 2 pull-up) and reads back in bits [1:0]. A 1 written to bit n%32 of a pull-strobe word (0x98, 0x9C) copies the current mode into pin n's pull state, which appears on `pin_pull[2n+1:2n]`. Pins that are not strobed keep their state.
- R8: Reads of the set, clear and pull-strobe words return 0. Accesses to unmapped offsets read 0 and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational during a read |
| pin_in | input | 54 | Raw pin levels |
| pin_out | output | 54 | Stored output value per pin |
| pin_oe | output | 54 | Output enable per pin |
| pin_pull | output | 108 | Pull state, 2 bits per pin |
| pin_func | output | 162 | Function code, 3 bits per pin |

## Verification
The bench covers the following corner cases:
- A full-ones write to the last function word. A design that let the unused bits through would read back bits above 11 or spill into nonexistent pins.
- A set write and a clear write whose other bits are zero. A design that treated the word as a plain output register would wipe the pins it should leave alone.
- Set writes to a pin that is not an output. A design that dropped these would lose the level the pin should drive once it becomes an output.
- Reading the level word after one edge and again after two edges. A missing or extra synchroniser stage shows up as a value that arrives too early or too late.
- The pull sequence, including a change of the control word after the strobe. This shows that only strobed pins latch the mode, and that clearing the registers does not disturb the latched state.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int PINS_PER_FWORD = 10;
  localparam int FCODE_W        = 3;
  localparam int PULL_W         = 2;

  localparam int FSEL_BASE  = 'h00;
  localparam int SET_BASE   = 'h1C;
  localparam int CLR_BASE   = 'h28;
  localparam int LEV_BASE   = 'h34;
  localparam int PULL_OFS   = 'h94;
  localparam int PSTB_BASE  = 'h98;

  localparam logic [FCODE_W-1:0] FCODE_IN  = 3'd0;
  localparam logic [FCODE_W-1:0] FCODE_OUT = 3'd1;

  localparam logic [PULL_W-1:0] PULL_NONE = 2'd0;
  localparam logic [PULL_W-1:0] PULL_DOWN = 2'd1;
  localparam logic [PULL_W-1:0] PULL_UP   = 2'd2;
endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int AW         = 8,
  parameter int FSEL_WORDS = 6,
  parameter int BIT_WORDS  = 2
) (
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [AW-1:0]         bus_addr,
  output logic [FSEL_WORDS-1:0] fsel_we,
  output logic [BIT_WORDS-1:0]  set_we,
  output logic [BIT_WORDS-1:0]  clr_we,
  output logic [BIT_WORDS-1:0]  pstb_we,
  output logic                  pull_we
);
  logic wr_en;
  assign wr_en = bus_sel & bus_wr;

  for (genvar w = 0; w < FSEL_WORDS; w++) begin : g_fsel
    assign fsel_we[w] = wr_en && (int'(bus_addr) == FSEL_BASE + 4*w);
  end

  for (genvar w = 0; w < BIT_WORDS; w++) begin : g_bits
    assign set_we[w]  = wr_en && (int'(bus_addr) == SET_BASE  + 4*w);
    assign clr_we[w]  = wr_en && (int'(bus_addr) == CLR_BASE  + 4*w);
    assign pstb_we[w] = wr_en && (int'(bus_addr) == PSTB_BASE + 4*w);
  end

  assign pull_we = wr_en && (int'(bus_addr) == PULL_OFS);
endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W = 54
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= din;
      stage2_q <= stage1_q;
    end
  end

  assign dout = stage2_q;
endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
  import gpio_bank_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fsel_we,
  input  logic [FCODE_W-1:0] fsel_code,
  input  logic               set_hit,
  input  logic               clr_hit,
  input  logic               pstb_hit,
  input  logic [PULL_W-1:0]  pull_ctrl,
  output logic [FCODE_W-1:0] func,
  output logic               out_val,
  output logic               oe,
  output logic [PULL_W-1:0]  pull
);
  logic [FCODE_W-1:0] func_q, func_d;
  logic               out_q, out_d;
  logic [PULL_W-1:0]  pull_q, pull_d;

  always_comb begin
    func_d = func_q;
    out_d  = out_q;
    pull_d = pull_q;
    if (fsel_we)  func_d = fsel_code;
    if (set_hit)      out_d = 1'b1;
    else if (clr_hit) out_d = 1'b0;
    if (pstb_hit) pull_d = pull_ctrl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q <= FCODE_IN;
      out_q  <= 1'b0;
      pull_q <= PULL_NONE;
    end else begin
      func_q <= func_d;
      out_q  <= out_d;
      pull_q <= pull_d;
    end
  end

  assign func    = func_q;
  assign out_val = out_q;
  assign oe      = (func_q == FCODE_OUT);
  assign pull    = pull_q;

  // R3
  set_drives_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> out_val);

  // R4
  clr_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !set_hit) |=> !out_val);

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_hit && !clr_hit) |=> $stable(out_val));

  // R7
  pull_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pstb_hit |=> (pull == $past(pull_ctrl)));

  // R7
  pull_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pstb_hit |=> $stable(pull));

  // R5
  oe_needs_fsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> $past(fsel_we));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int AW       = 8,
  parameter int DW       = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_sel,
  input  logic                        bus_wr,
  input  logic [AW-1:0]               bus_addr,
  input  logic [DW-1:0]               bus_wdata,
  output logic [DW-1:0]               bus_rdata,
  input  logic [NUM_PINS-1:0]         pin_in,
  output logic [NUM_PINS-1:0]         pin_out,
  output logic [NUM_PINS-1:0]         pin_oe,
  output logic [PULL_W*NUM_PINS-1:0]  pin_pull,
  output logic [FCODE_W*NUM_PINS-1:0] pin_func
);
  localparam int FSEL_WORDS = (NUM_PINS + PINS_PER_FWORD - 1) / PINS_PER_FWORD;
  localparam int BIT_WORDS  = (NUM_PINS + DW - 1) / DW;

  logic [FSEL_WORDS-1:0] fsel_we;
  logic [BIT_WORDS-1:0]  set_we, clr_we, pstb_we;
  logic                  pull_we;
  logic [PULL_W-1:0]     pull_ctrl_q, pull_ctrl_d;
  logic [NUM_PINS-1:0]   lev_sync;
  logic [FCODE_W-1:0]    func_all [NUM_PINS];
  logic [DW-1:0]         fsel_rd  [FSEL_WORDS];
  logic [DW-1:0]         lev_rd   [BIT_WORDS];
  logic                  rd_en;

  gpio_bank_decode #(
    .AW(AW), .FSEL_WORDS(FSEL_WORDS), .BIT_WORDS(BIT_WORDS)
  ) u_decode (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .fsel_we (fsel_we),
    .set_we  (set_we),
    .clr_we  (clr_we),
    .pstb_we (pstb_we),
    .pull_we (pull_we)
  );

  gpio_bank_sync #(.W(NUM_PINS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_in),
    .dout (lev_sync)
  );

  // shared pull mode word
  always_comb begin
    pull_ctrl_d = pull_ctrl_q;
    if (pull_we) pull_ctrl_d = bus_wdata[PULL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pull_ctrl_q <= PULL_NONE;
    else        pull_ctrl_q <= pull_ctrl_d;
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    localparam int FW = n / PINS_PER_FWORD;
    localparam int FB = FCODE_W * (n % PINS_PER_FWORD);
    localparam int BW = n / DW;
    localparam int BB = n % DW;

    gpio_pin_slice u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .fsel_we  (fsel_we[FW]),
      .fsel_code(bus_wdata[FB +: FCODE_W]),
      .set_hit  (set_we[BW] & bus_wdata[BB]),
      .clr_hit  (clr_we[BW] & bus_wdata[BB]),
      .pstb_hit (pstb_we[BW] & bus_wdata[BB]),
      .pull_ctrl(pull_ctrl_q),
      .func     (func_all[n]),
      .out_val  (pin_out[n]),
      .oe       (pin_oe[n]),
      .pull     (pin_pull[PULL_W*n +: PULL_W])
    );

    assign pin_func[FCODE_W*n +: FCODE_W] = func_all[n];
  end

  // read words assembled from pin state
  always_comb begin
    for (int w = 0; w < FSEL_WORDS; w++) begin
      fsel_rd[w] = '0;
      for (int k = 0; k < PINS_PER_FWORD; k++) begin
        if (w*PINS_PER_FWORD + k < NUM_PINS)
          fsel_rd[w][FCODE_W*k +: FCODE_W] = func_all[w*PINS_PER_FWORD + k];
      end
    end
    for (int w = 0; w < BIT_WORDS; w++) begin
      lev_rd[w] = '0;
      for (int b = 0; b < DW; b++) begin
        if (w*DW + b < NUM_PINS) lev_rd[w][b] = lev_sync[w*DW + b];
      end
    end
  end

  assign rd_en = bus_sel & ~bus_wr;

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      for (int w = 0; w < FSEL_WORDS; w++)
        if (int'(bus_addr) == FSEL_BASE + 4*w) bus_rdata = fsel_rd[w];
      for (int w = 0; w < BIT_WORDS; w++)
        if (int'(bus_addr) == LEV_BASE + 4*w) bus_rdata = lev_rd[w];
      if (int'(bus_addr) == PULL_OFS)
        bus_rdata = {{(DW-PULL_W){1'b0}}, pull_ctrl_q};
    end
  end

  // R8
  strobe_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (int'(bus_addr) == SET_BASE || int'(bus_addr) == CLR_BASE ||
               int'(bus_addr) == PSTB_BASE)) |-> (bus_rdata == '0));

  // R7
  pull_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pull_we |=> (pull_ctrl_q == $past(bus_wdata[PULL_W-1:0])));
endmodule

// File: tb/gpio_bank_regs_bench.sv
module gpio_bank_regs_bench;
  localparam int NP = 54;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel, bus_wr;
  logic [7:0]    bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [NP-1:0] pin_in, pin_out, pin_oe;
  logic [2*NP-1:0] pin_pull;
  logic [3*NP-1:0] pin_func;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_bank_regs u_gpio_bank_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_pull(pin_pull), .pin_func(pin_func)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 oe", 64'(pin_oe), 64'd0);
    chk("R1 out", 64'(pin_out), 64'd0);
    chk("R1 pull lo", pin_pull[63:0], 64'd0);
    chk("R1 func lo", pin_func[63:0], 64'd0);
    rd(8'h00, d); chk("R1 fsel word0", 64'(d), 64'd0);
    rd(8'h94, d); chk("R1 pull word", 64'(d), 64'd0);
  endtask

  task automatic t_fsel();
    logic [31:0] d;
    wr(8'h00, 32'hB8000A01);
    rd(8'h00, d); chk("R2 word0 readback", 64'(d), 64'h38000A01);
    chk("R2 pin0 code", 64'(pin_func[2:0]), 64'd1);
    chk("R2 pin3 code", 64'(pin_func[11:9]), 64'd5);
    chk("R2 pin9 code", 64'(pin_func[29:27]), 64'd7);
    chk("R5 pin0 oe", 64'(pin_oe[0]), 64'd1);
    chk("R5 pin3 oe", 64'(pin_oe[3]), 64'd0);
    wr(8'h14, 32'hFFFFFFFF);
    rd(8'h14, d); chk("R2 last word mask", 64'(d), 64'h00000FFF);
    chk("R2 pins50-53", 64'(pin_func[161:150]), 64'hFFF);
    chk("R5 pins50-53 oe", 64'(pin_oe[53:50]), 64'h0);
    wr(8'h0C, 32'h00200000);
    chk("R2 pin37 code", 64'(pin_func[113:111]), 64'd1);
    chk("R5 pin37 oe", 64'(pin_oe[37]), 64'd1);
  endtask

  task automatic t_setclr();
    logic [31:0] d;
    wr(8'h1C, 32'h00000009);
    chk("R3 set 0,3", 64'(pin_out), 64'h9);
    chk("R5 non-output pin3 stored", 64'(pin_out[3]), 64'd1);
    wr(8'h28, 32'h00000001);
    chk("R4 clr pin0", 64'(pin_out), 64'h8);
    wr(8'h20, 32'hFFC00020);
    chk("R3 set pin37 only", 64'(pin_out), (64'h1 << 37) | 64'h8);
    wr(8'h2C, 32'h0);
    chk("R4 zero clear no effect", 64'(pin_out), (64'h1 << 37) | 64'h8);
    wr(8'h1C, 32'h0);
    chk("R3 zero set no effect", 64'(pin_out), (64'h1 << 37) | 64'h8);
    rd(8'h1C, d); chk("R8 set reads 0", 64'(d), 64'd0);
    rd(8'h2C, d); chk("R8 clr reads 0", 64'(d), 64'd0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    @(negedge clk);
    pin_in = {NP{1'b1}};
    @(posedge clk);
    rd(8'h34, d); chk("R6 one edge still old", 64'(d), 64'd0);
    rd(8'h34, d); chk("R6 low word", 64'(d), 64'hFFFFFFFF);
    rd(8'h38, d); chk("R6 high word mask", 64'(d), 64'h003FFFFF);
    @(negedge clk);
    pin_in = 54'h2A_0000_0001;
    @(posedge clk); @(posedge clk);
    rd(8'h38, d); chk("R6 pattern high", 64'(d), 64'h2A);
    rd(8'h34, d); chk("R6 pattern low", 64'(d), 64'h1);
  endtask

  task automatic t_pull();
    logic [31:0] d;
    wr(8'h94, 32'h2);
    rd(8'h94, d); chk("R7 ctrl readback", 64'(d), 64'd2);
    wr(8'h98, 32'h10);
    wr(8'h94, 32'h0);
    wr(8'h98, 32'h0);
    chk("R7 pin4 pull-up", 64'(pin_pull[9:8]), 64'd2);
    chk("R7 others none", pin_pull[63:0] & ~64'h300, 64'd0);
    wr(8'h94, 32'h1);
    wr(8'h9C, 32'h00200000);
    wr(8'h94, 32'h0);
    wr(8'h9C, 32'h0);
    chk("R7 pin53 pull-down", 64'(pin_pull[107:106]), 64'd1);
    chk("R7 pin4 kept", 64'(pin_pull[9:8]), 64'd2);
    rd(8'h98, d); chk("R8 strobe reads 0", 64'(d), 64'd0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    logic [NP-1:0] o_snap, e_snap;
    logic [2*NP-1:0] p_snap;
    logic [3*NP-1:0] f_snap;
    o_snap = pin_out; e_snap = pin_oe; p_snap = pin_pull; f_snap = pin_func;
    wr(8'hA0, 32'hFFFFFFFF);
    wr(8'h18, 32'hFFFFFFFF);
    wr(8'h40, 32'hFFFFFFFF);
    chk("R8 out unchanged", 64'(pin_out ^ o_snap), 64'd0);
    chk("R8 oe unchanged", 64'(pin_oe ^ e_snap), 64'd0);
    chk("R8 pull unchanged", 64'(|(pin_pull ^ p_snap)), 64'd0);
    chk("R8 func unchanged", 64'(|(pin_func ^ f_snap)), 64'd0);
    rd(8'hA0, d); chk("R8 unmapped reads 0", 64'(d), 64'd0);
    rd(8'h18, d); chk("R8 past fsel reads 0", 64'(d), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0; pin_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_fsel();
    t_setclr();
    t_level();
    t_pull();
    t_unmapped();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule